// File: doc/BRIEF.md
# Instruction Address Compare Unit

This block watches the instruction-fetch address stream of a processor core and raises debug compare events. Two compare registers hold word addresses. A supervisor-written control word gives each comparator its own filters, one on privilege (the problem-state bit) and one on address space (the instruction-space bit). It also sets a pair mode. In that mode the two comparators either match equality independently, or they merge into a single inclusive or exclusive range test.

Events are registered, so each one appears as a one-cycle pulse on the clock edge after the qualifying fetch. An optional auto-toggle flips the pair between inclusive and exclusive range after each range hit. Debug software can use this to catch both the entry into an address window and the exit from it. The current mode is always visible on the control readback.

Top module: `iac_unit`

## Requirements
- R1: After reset, the control readback is 0x0000_0000, both compare registers are zero and both event outputs are low.
- R2: Each comparator has a privilege filter: 2'b00 passes in any state, 2'b10 passes only when pr_i=0, 2'b11 passes only when pr_i=1. Comparator 1 uses control bits [31:30] and comparator 2 uses bits [27:26].
- R3: Each comparator has a space filter: 2'b00 ignores is_i, 2'b10 requires is_i=0, 2'b11 requires is_i=1. Comparator 1 uses control bits [29:28] and comparator 2 uses bits [25:24].
- R4: Pair mode (control bits [23:22]) 2'b00 is exact. Event 1 fires when comparator 1's filters pass and fetch_addr_i[31:2] equals compare register 1 bits [31:2]. Event 2 works the same way with comparator 2. Address bits [1:0] never matter.
- R5: Pair mode 2'b10 is inclusive range. A hit occurs when cmp1[31:2] <= addr[31:2] < cmp2[31:2] (unsigned).
- R6: Pair mode 2'b11 is exclusive range. A hit occurs when addr[31:2] < cmp1[31:2] or addr[31:2] >= cmp2[31:2] (unsigned).
- R7: The reserved encoding 2'b01 of the pair mode, or of any filter field, produces no match.
- R8: Only control bits [31:22] and bit 16 (auto-toggle enable) are stored. All other bits read back as zero.
- R9: In either range mode, both comparators' filters must pass. A range hit drives event1_o and event2_o high in the same cycle.
- R10: When auto-toggle is set and a valid fetch makes a range hit, control bit 22 flips, swapping inclusive and exclusive range for later fetches. A control write in the same cycle takes priority over the flip.
- R11: An event goes high only on the clock edge right after a cycle in which fetch_valid_i is high and the match holds, and it lasts one cycle.
- R12: A register write takes effect from the next cycle on. A fetch in the same cycle as the write is judged with the old values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fetch_valid_i | input | 1 | Fetch address is valid this cycle |
| fetch_addr_i | input | 32 | Instruction-fetch address |
| pr_i | input | 1 | Problem state (1 = user) |
| is_i | input | 1 | Instruction address-space bit |
| ctrl_we_i | input | 1 | Control word write enable |
| ctrl_wdata_i | input | 32 | Control word write data |
| cmp1_we_i | input | 1 | Compare register 1 write enable |
| cmp1_wdata_i | input | 32 | Compare register 1 write data |
| cmp2_we_i | input | 1 | Compare register 2 write enable |
| cmp2_wdata_i | input | 32 | Compare register 2 write data |
| ctrl_rdata_o | output | 32 | Control word readback |
| event1_o | output | 1 | Comparator 1 event pulse |
| event2_o | output | 1 | Comparator 2 event pulse |

## Verification
Each event is due exactly one rising edge after the cycle in which its fetch is presented. A toggled or newly written control word shows on the readback after that same edge. The driver applies every cycle's inputs on the falling edge and pushes the expected pair of events. The monitor pops that entry 1 ns after the next rising edge, so each comparison lines up with the single register stage. Control readback checks are sampled at that same point, before the next fetch can change anything.

// File: rtl/iac_pkg.sv
package iac_pkg;
  localparam int CTRL_W = 32;

  // Field positions, little-endian view of the control word
  localparam int PRIV1_HI = 31;
  localparam int SP1_HI   = 29;
  localparam int PRIV2_HI = 27;
  localparam int SP2_HI   = 25;
  localparam int MODE_HI  = 23;
  localparam int MODE_LO  = 22;
  localparam int ATOG_BIT = 16;

  localparam logic [CTRL_W-1:0] CTRL_WMASK =
    (32'h3FF << MODE_LO) | (32'h1 << ATOG_BIT);

  typedef enum logic [1:0] {
    QUAL_ANY  = 2'b00,
    QUAL_RSVD = 2'b01,
    QUAL_LOW  = 2'b10,
    QUAL_HIGH = 2'b11
  } qual_e;

  typedef enum logic [1:0] {
    PM_EXACT = 2'b00,
    PM_RSVD  = 2'b01,
    PM_INCL  = 2'b10,
    PM_EXCL  = 2'b11
  } pair_mode_e;

  typedef struct packed {
    qual_e      priv1;
    qual_e      sp1;
    qual_e      priv2;
    qual_e      sp2;
    pair_mode_e mode;
    logic       atog;
  } ctrl_t;

  function automatic ctrl_t decode_ctrl(input logic [CTRL_W-1:0] w);
    ctrl_t c;
    c.priv1 = qual_e'(w[PRIV1_HI -: 2]);
    c.sp1   = qual_e'(w[SP1_HI -: 2]);
    c.priv2 = qual_e'(w[PRIV2_HI -: 2]);
    c.sp2   = qual_e'(w[SP2_HI -: 2]);
    c.mode  = pair_mode_e'(w[MODE_HI -: 2]);
    c.atog  = w[ATOG_BIT];
    return c;
  endfunction
endpackage

// File: rtl/iac_ctrl_reg.sv
module iac_ctrl_reg import iac_pkg::*; (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [CTRL_W-1:0] wdata_i,
  input  logic              toggle_i,
  output logic [CTRL_W-1:0] q_o
);
  localparam logic [CTRL_W-1:0] TOG_MASK = CTRL_W'(1) << MODE_LO;

  logic [CTRL_W-1:0] ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ctrl_q <= '0;
    else if (we_i)     ctrl_q <= wdata_i & CTRL_WMASK;
    else if (toggle_i) ctrl_q <= ctrl_q ^ TOG_MASK;
  end

  assign q_o = ctrl_q;
endmodule

// File: rtl/iac_qual.sv
module iac_qual import iac_pkg::*; (
  input  qual_e priv_i,
  input  qual_e sp_i,
  input  logic  pr_i,
  input  logic  is_i,
  output logic  pass_o
);
  function automatic logic qual_ok(input qual_e sel, input logic bit_v);
    case (sel)
      QUAL_ANY:  return 1'b1;
      QUAL_LOW:  return !bit_v;
      QUAL_HIGH: return bit_v;
      default:   return 1'b0;
    endcase
  endfunction

  assign pass_o = qual_ok(priv_i, pr_i) && qual_ok(sp_i, is_i);
endmodule

// File: rtl/iac_addr_cmp.sv
module iac_addr_cmp #(
  parameter int ADDR_W  = 32,
  parameter int IGN_LSB = 2
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] cmp_i,
  output logic              eq_o,
  output logic              lt_o
);
  localparam logic [ADDR_W-1:0] WMASK = {ADDR_W{1'b1}} << IGN_LSB;

  logic [ADDR_W-1:0] a_m, c_m;
  assign a_m  = addr_i & WMASK;
  assign c_m  = cmp_i & WMASK;
  assign eq_o = (a_m == c_m);
  assign lt_o = (a_m < c_m);
endmodule

// File: rtl/iac_unit.sv
module iac_unit import iac_pkg::*; #(
  parameter int ADDR_W  = 32,
  parameter int IGN_LSB = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fetch_valid_i,
  input  logic [ADDR_W-1:0] fetch_addr_i,
  input  logic              pr_i,
  input  logic              is_i,
  input  logic              ctrl_we_i,
  input  logic [CTRL_W-1:0] ctrl_wdata_i,
  input  logic              cmp1_we_i,
  input  logic [ADDR_W-1:0] cmp1_wdata_i,
  input  logic              cmp2_we_i,
  input  logic [ADDR_W-1:0] cmp2_wdata_i,
  output logic [CTRL_W-1:0] ctrl_rdata_o,
  output logic              event1_o,
  output logic              event2_o
);
  localparam int NCMP = 2;

  ctrl_t             ctl;
  logic              range_hit, hit1, hit2, toggle;
  logic [NCMP-1:0]   cmp_we, pass, eq, lt;
  logic [ADDR_W-1:0] cmp_wdata [NCMP];
  logic [ADDR_W-1:0] cmp_q     [NCMP];
  qual_e             priv_sel  [NCMP];
  qual_e             sp_sel    [NCMP];

  iac_ctrl_reg i_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (ctrl_we_i),
    .wdata_i  (ctrl_wdata_i),
    .toggle_i (toggle),
    .q_o      (ctrl_rdata_o)
  );

  assign ctl = decode_ctrl(ctrl_rdata_o);

  assign cmp_we[0]    = cmp1_we_i;
  assign cmp_we[1]    = cmp2_we_i;
  assign cmp_wdata[0] = cmp1_wdata_i;
  assign cmp_wdata[1] = cmp2_wdata_i;
  assign priv_sel[0]  = ctl.priv1;
  assign priv_sel[1]  = ctl.priv2;
  assign sp_sel[0]    = ctl.sp1;
  assign sp_sel[1]    = ctl.sp2;

  for (genvar g = 0; g < NCMP; g++) begin : g_cmp
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        cmp_q[g] <= '0;
      else if (cmp_we[g]) cmp_q[g] <= cmp_wdata[g];
    end

    iac_qual i_qual (
      .priv_i (priv_sel[g]),
      .sp_i   (sp_sel[g]),
      .pr_i   (pr_i),
      .is_i   (is_i),
      .pass_o (pass[g])
    );

    iac_addr_cmp #(.ADDR_W(ADDR_W), .IGN_LSB(IGN_LSB)) i_acmp (
      .addr_i (fetch_addr_i),
      .cmp_i  (cmp_q[g]),
      .eq_o   (eq[g]),
      .lt_o   (lt[g])
    );
  end

  always_comb begin
    hit1      = 1'b0;
    hit2      = 1'b0;
    range_hit = 1'b0;
    case (ctl.mode)
      PM_EXACT: begin
        hit1 = pass[0] && eq[0];
        hit2 = pass[1] && eq[1];
      end
      PM_INCL: range_hit = &pass && !lt[0] && lt[1];
      PM_EXCL: range_hit = &pass && (lt[0] || !lt[1]);
      default: ;
    endcase
    if (range_hit) begin
      hit1 = 1'b1;
      hit2 = 1'b1;
    end
  end

  assign toggle = fetch_valid_i && range_hit && ctl.atog;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      event1_o <= 1'b0;
      event2_o <= 1'b0;
    end else begin
      event1_o <= fetch_valid_i && hit1;
      event2_o <= fetch_valid_i && hit2;
    end
  end
endmodule

// File: rtl/iac_unit_chk.sv
module iac_unit_chk import iac_pkg::*; (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              fetch_valid_i,
  input logic              ctrl_we_i,
  input logic [CTRL_W-1:0] ctrl_rdata_o,
  input logic              event1_o,
  input logic              event2_o
);
  a_r11_event_needs_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (event1_o || event2_o) |-> $past(fetch_valid_i));

  a_r9_range_both_events: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(ctrl_rdata_o[MODE_HI]) |-> (event1_o == event2_o));

  a_r7_rsvd_mode_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(ctrl_rdata_o[MODE_HI -: 2]) == PM_RSVD) |-> (!event1_o && !event2_o));

  a_r8_rsvd_bits_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_rdata_o & ~CTRL_WMASK) == '0);

  a_r10_autotoggle_flip: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(fetch_valid_i && !ctrl_we_i && ctrl_rdata_o[ATOG_BIT] && ctrl_rdata_o[MODE_HI])
      && event1_o) |-> (ctrl_rdata_o[MODE_LO] != $past(ctrl_rdata_o[MODE_LO])));
endmodule

bind iac_unit iac_unit_chk i_iac_unit_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .fetch_valid_i (fetch_valid_i),
  .ctrl_we_i     (ctrl_we_i),
  .ctrl_rdata_o  (ctrl_rdata_o),
  .event1_o      (event1_o),
  .event2_o      (event2_o)
);

// File: tb/test_iac_unit.sv
module test_iac_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fv = 1'b0, pr = 1'b0, is_b = 1'b0;
  logic [31:0] addr = '0;
  logic        cwe = 1'b0, w1 = 1'b0, w2 = 1'b0;
  logic [31:0] cdat = '0, d1 = '0, d2 = '0;
  logic [31:0] rdata;
  logic        ev1, ev2;

  always #2 clk = ~clk;

  iac_unit i_iac_unit (
    .clk_i(clk), .rst_ni(rst_n), .fetch_valid_i(fv), .fetch_addr_i(addr),
    .pr_i(pr), .is_i(is_b), .ctrl_we_i(cwe), .ctrl_wdata_i(cdat),
    .cmp1_we_i(w1), .cmp1_wdata_i(d1), .cmp2_we_i(w2), .cmp2_wdata_i(d2),
    .ctrl_rdata_o(rdata), .event1_o(ev1), .event2_o(ev2)
  );

  int checks = 0, fails = 0;
  typedef struct { logic e1; logic e2; string tag; } exp_t;
  exp_t sb[$];
  logic [31:0] m_ctrl = '0, m_c1 = '0, m_c2 = '0;

  function automatic logic [31:0] mk(input logic [1:0] p1, s1, p2, s2, m, input logic at);
    return {p1, s1, p2, s2, m, 5'b0, at, 16'h0};
  endfunction

  function automatic logic qpass(input logic [1:0] s, input logic b);
    case (s)
      2'b00:   return 1'b1;
      2'b10:   return !b;
      2'b11:   return b;
      default: return 1'b0;
    endcase
  endfunction

  task automatic step(input logic v, input logic [31:0] a, input logic p, i,
                      input logic cw, input logic [31:0] cd,
                      input logic x1, input logic [31:0] y1,
                      input logic x2, input logic [31:0] y2, input string tag);
    exp_t e;
    logic q1, q2, hit;
    logic [29:0] aw, c1w, c2w;
    @(negedge clk);
    fv = v; addr = a; pr = p; is_b = i; cwe = cw; cdat = cd;
    w1 = x1; d1 = y1; w2 = x2; d2 = y2;
    q1 = qpass(m_ctrl[31:30], p) && qpass(m_ctrl[29:28], i);
    q2 = qpass(m_ctrl[27:26], p) && qpass(m_ctrl[25:24], i);
    aw = a[31:2]; c1w = m_c1[31:2]; c2w = m_c2[31:2];
    e.e1 = 1'b0; e.e2 = 1'b0; hit = 1'b0;
    case (m_ctrl[23:22])
      2'b00: begin e.e1 = q1 && (aw == c1w); e.e2 = q2 && (aw == c2w); end
      2'b10: hit = q1 && q2 && (c1w <= aw) && (aw < c2w);
      2'b11: hit = q1 && q2 && ((aw < c1w) || (aw >= c2w));
      default: ;
    endcase
    if (m_ctrl[23]) begin e.e1 = hit; e.e2 = hit; end
    if (!v) begin e.e1 = 1'b0; e.e2 = 1'b0; end
    e.tag = tag;
    sb.push_back(e);
    if (v && hit && m_ctrl[16]) m_ctrl[22] = ~m_ctrl[22];
    if (cw) m_ctrl = cd & 32'hFFC1_0000;
    if (x1) m_c1 = y1;
    if (x2) m_c2 = y2;
    @(posedge clk);
  endtask

  task automatic fetch(input logic [31:0] a, input logic p, i, input string tag);
    step(1'b1, a, p, i, 1'b0, '0, 1'b0, '0, 1'b0, '0, tag);
  endtask

  task automatic wctrl(input logic [31:0] v);
    step(1'b0, '0, 1'b0, 1'b0, 1'b1, v, 1'b0, '0, 1'b0, '0, "R12 write");
  endtask

  task automatic check_ctrl(input logic [31:0] exp, input string tag);
    #1;
    checks++;
    if (rdata !== exp) begin
      fails++;
      $display("FAIL %s: ctrl readback %h expected %h", tag, rdata, exp);
    end
  endtask

  // monitor: result due one edge after the driven cycle
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() != 0) begin
        exp_t e;
        e = sb.pop_front();
        checks++;
        if (ev1 !== e.e1 || ev2 !== e.e2) begin
          fails++;
          $display("FAIL %s: events %b%b expected %b%b", e.tag, ev1, ev2, e.e1, e.e2);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not complete");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (rdata !== 32'h0 || ev1 !== 1'b0 || ev2 !== 1'b0) begin
      fails++;
      $display("FAIL R1: reset ctrl %h ev %b%b expected 00000000 00", rdata, ev1, ev2);
    end
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk);
    check_ctrl(32'h0, "R1 after release");
    fetch(32'h0000_0000, 1'b0, 1'b0, "R1 zero compare regs");

    step(1'b0, '0, 0, 0, 1'b0, '0, 1'b1, 32'h0000_1000, 1'b1, 32'h0000_2000, "R12 cmp write");
    fetch(32'h0000_1000, 0, 0, "R4 exact cmp1");
    fetch(32'h0000_1003, 1, 1, "R4 low bits ignored");
    fetch(32'h0000_2000, 0, 1, "R4 exact cmp2");
    fetch(32'h0000_1004, 0, 0, "R4 no match");
    step(1'b0, 32'h0000_1000, 0, 0, 1'b0, '0, 1'b0, '0, 1'b0, '0, "R11 no valid");

    wctrl(mk(2'b10, 2'b00, 2'b11, 2'b00, 2'b00, 1'b0));
    check_ctrl(mk(2'b10, 2'b00, 2'b11, 2'b00, 2'b00, 1'b0), "R8 layout");
    fetch(32'h0000_1000, 1, 0, "R2 supervisor only, user fetch");
    fetch(32'h0000_1000, 0, 0, "R2 supervisor only, supervisor fetch");
    fetch(32'h0000_2000, 0, 0, "R2 user only, supervisor fetch");
    fetch(32'h0000_2000, 1, 0, "R2 user only, user fetch");

    wctrl(mk(2'b01, 2'b00, 2'b00, 2'b10, 2'b00, 1'b0));
    fetch(32'h0000_1000, 0, 0, "R7 reserved privilege filter");
    fetch(32'h0000_2000, 0, 1, "R3 space 0 required, is=1");
    fetch(32'h0000_2000, 1, 0, "R3 space 0 required, is=0");
    wctrl(mk(2'b00, 2'b11, 2'b00, 2'b01, 2'b00, 1'b0));
    fetch(32'h0000_1000, 0, 0, "R3 space 1 required, is=0");
    fetch(32'h0000_1000, 0, 1, "R3 space 1 required, is=1");
    fetch(32'h0000_2000, 0, 1, "R7 reserved space filter");

    wctrl(mk(2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 1'b0));
    step(1'b1, 32'h0000_1000, 0, 0, 1'b1, mk(2'b01, 2'b00, 2'b00, 2'b00, 2'b00, 1'b0),
         1'b0, '0, 1'b0, '0, "R12 same-cycle fetch uses old ctrl");
    fetch(32'h0000_1000, 0, 0, "R12 new ctrl applied");

    wctrl(32'hFFFF_FFFF);
    check_ctrl(32'hFFC1_0000, "R8 reserved bits zero");

    wctrl(mk(2'b00, 2'b00, 2'b00, 2'b00, 2'b10, 1'b0));
    fetch(32'h0000_0FFC, 0, 0, "R5 below range");
    fetch(32'h0000_1000, 0, 0, "R5 low bound inclusive");
    fetch(32'h0000_1FFF, 1, 1, "R5 top word");
    fetch(32'h0000_2000, 0, 0, "R5 upper bound excluded");
    wctrl(mk(2'b00, 2'b00, 2'b10, 2'b00, 2'b10, 1'b0));
    fetch(32'h0000_1800, 1, 0, "R9 cmp2 filter blocks range");
    fetch(32'h0000_1800, 0, 0, "R9 both filters pass");

    wctrl(mk(2'b00, 2'b00, 2'b00, 2'b00, 2'b11, 1'b0));
    fetch(32'h0000_0FFC, 0, 0, "R6 below low");
    fetch(32'h0000_1000, 0, 0, "R6 at low");
    fetch(32'h0000_1FFF, 0, 0, "R6 top inside");
    fetch(32'h0000_2000, 0, 0, "R6 at high");

    wctrl(mk(2'b00, 2'b00, 2'b00, 2'b00, 2'b01, 1'b0));
    fetch(32'h0000_1000, 0, 0, "R7 reserved mode");
    fetch(32'h0000_3000, 0, 0, "R7 reserved mode high");

    wctrl(mk(2'b00, 2'b00, 2'b00, 2'b00, 2'b10, 1'b1));
    fetch(32'h0000_3000, 0, 0, "R10 miss no toggle");
    check_ctrl(mk(2'b00, 2'b00, 2'b00, 2'b00, 2'b10, 1'b1), "R10 mode kept");
    fetch(32'h0000_1800, 0, 0, "R10 inclusive hit");
    check_ctrl(mk(2'b00, 2'b00, 2'b00, 2'b00, 2'b11, 1'b1), "R10 toggled to exclusive");
    fetch(32'h0000_1800, 0, 0, "R10 exclusive miss");
    fetch(32'h0000_3000, 0, 0, "R10 exclusive hit");
    check_ctrl(mk(2'b00, 2'b00, 2'b00, 2'b00, 2'b10, 1'b1), "R10 toggled back");
    step(1'b1, 32'h0000_1800, 0, 0, 1'b1, mk(2'b00, 2'b00, 2'b00, 2'b00, 2'b10, 1'b1),
         1'b0, '0, 1'b0, '0, "R10 write beats toggle");
    check_ctrl(mk(2'b00, 2'b00, 2'b00, 2'b00, 2'b10, 1'b1), "R10 write priority");

    repeat (3) step(1'b0, '0, 0, 0, 1'b0, '0, 1'b0, '0, 1'b0, '0, "R11 idle");
    @(posedge clk);
    #2;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule